// File: doc/BRIEF.md
# Serial Port FIFO Interrupt Flag Controller

This block keeps the five status flags of a serial port that has a transmit FIFO and a receive FIFO, and it turns those flags into interrupt and DMA requests. It watches the fill counts of both FIFOs against programmable trigger levels. It also latches one-cycle event pulses for a receive error, a line break and receive data ready. Software reads the flags through a small register port and clears them by handshake. A flag drops only after it has been read as 1 and a 0 has then been written to its bit. For the two FIFO-level flags, the level condition must also hold when the 0 is written.

Every flag is a small three-state machine with the states FL_CLEAR, FL_SET and FL_ARMED. The transitions are:
- set: FL_CLEAR to FL_SET, on a set condition.
- arm: FL_SET to FL_ARMED, on a read strobe while the flag reads 1.
- clear: FL_ARMED to FL_CLEAR, on a write of 0 while clearing is allowed.
- re-set: FL_ARMED to FL_SET, on a write of 0 that meets a new set condition in the same cycle.

Every other combination holds the state. Four request lines leave the block, each gated by an enable. Two DMA request lines also leave it. An encoded output names the highest-priority request that is active.

Top module: `uart_irq_flagctl`

## Requirements
- R1: After reset, the status reads 5'b10000: only the transmit-empty flag is set. The encoded source reads 0 while the transmit enable is low.
- R2: Status bit positions: bit0 is the receive error, bit1 is break, bit2 is data ready, bit3 is receive full, and bit4 is transmit empty. `stat_rdata` shows the flags combinationally.
- R3: The transmit-empty flag sets on every cycle in which `tx_count <= tx_trig`. It clears only on a write of 0 that comes after it was read as 1, and only if `tx_count > tx_trig` at that write.
- R4: The receive-full flag sets on every cycle in which `rx_count >= rx_trig`. It clears only on a write of 0 that comes after it was read as 1, and only if `rx_count < rx_trig` at that write.
- R5: A pulse on `rx_err_evt`, `brk_evt` or `rdy_evt` sets its flag on the next clock edge. That flag clears on a write of 0 once it has been read as 1.
- R6: A write of 0 to a flag that has not been read as 1 leaves the flag set. A write of 1 has no effect on any flag.
- R7: The request lines follow these rules: `err_irq` = error AND `rx_irq_en`, `rxf_irq` = (receive full OR data ready) AND `rx_irq_en`, `brk_irq` = break AND `rx_irq_en`, and `txe_irq` = transmit empty AND `tx_irq_en`.
- R8: `dma_tx_req` = transmit empty AND `tx_irq_en`. `dma_rx_req` = receive full AND `rx_irq_en`. The data-ready flag, the error flag and the break flag never raise a DMA request.
- R9: `irq_src` reads 1 for the error request, 2 for the receive request, 3 for break, 4 for transmit and 0 for none. When several requests are active, it reports the highest one in the order error, receive, break, transmit.
- R10: A flag still sets and still reads back while its enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_count | input | CNT_W | Entries held in the transmit FIFO |
| rx_count | input | CNT_W | Entries held in the receive FIFO |
| tx_trig | input | CNT_W | Transmit trigger level |
| rx_trig | input | CNT_W | Receive trigger level |
| rx_err_evt | input | 1 | Receive error pulse |
| brk_evt | input | 1 | Break detect pulse |
| rdy_evt | input | 1 | Receive data ready pulse |
| tx_irq_en | input | 1 | Transmit interrupt enable |
| rx_irq_en | input | 1 | Receive-side interrupt enable |
| stat_rd | input | 1 | Status read strobe |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 5 | Status write data |
| stat_rdata | output | 5 | Status read data |
| err_irq | output | 1 | Receive error request |
| rxf_irq | output | 1 | Receive data request |
| brk_irq | output | 1 | Break request |
| txe_irq | output | 1 | Transmit empty request |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |
| irq_src | output | 3 | Encoded highest-priority active request |

## Verification
The bench sweeps every trigger level against every fill count on both sides. It checks that a complete read-then-write-0 handshake clears a level flag only when the count lies on the correct side of the trigger. A comparison that is off by one, or one that is inverted, would leave the flag stuck, or would drop it while the FIFO is still at the threshold. The bench runs every combination of the five flags under all four enable settings. This catches a priority encoder in the wrong order, a data-ready flag that leaks into the receive DMA request, and enables that wrongly suppress a flag as well as its request line. Separate checks write 0 without a prior read, and write 1 after a read. A design that drops a flag on any write would fail those checks.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int STAT_W = 5;
    localparam int B_ER   = 0;
    localparam int B_BRK  = 1;
    localparam int B_DR   = 2;
    localparam int B_RDF  = 3;
    localparam int B_TDFE = 4;

    typedef enum logic [1:0] {
        FL_CLEAR = 2'd0,
        FL_SET   = 2'd1,
        FL_ARMED = 2'd2
    } flag_state_t;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_ERR  = 3'd1,
        SRC_RXF  = 3'd2,
        SRC_BRK  = 3'd3,
        SRC_TXE  = 3'd4
    } irq_src_t;
endpackage

// File: rtl/flag_cell.sv
module flag_cell
    import uart_irq_pkg::*;
#(
    parameter bit RESET_SET = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_ok,
    input  logic rd_stb,
    input  logic wr_stb,
    input  logic wr_bit,
    output logic flag_o
);
    localparam flag_state_t RST_STATE = RESET_SET ? FL_SET : FL_CLEAR;

    flag_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RST_STATE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_CLEAR: begin
                if (set_req) state_d = FL_SET;
            end
            FL_SET: begin
                if (rd_stb) state_d = FL_ARMED;
            end
            FL_ARMED: begin
                if (wr_stb && !wr_bit && clr_ok)
                    state_d = set_req ? FL_SET : FL_CLEAR;
            end
            default: state_d = FL_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        flag_o = (state_q != FL_CLEAR);
    end

    // R6: a flag may only fall after an armed write of 0
    assert_clear_needs_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> $past(state_q == FL_ARMED && wr_stb && !wr_bit));

    // R5: a set condition is visible one edge later
    assert_set_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> flag_o);
endmodule

// File: rtl/irq_route.sv
module irq_route
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] flags,
    input  logic              tx_en,
    input  logic              rx_en,
    output logic              err_irq,
    output logic              rxf_irq,
    output logic              brk_irq,
    output logic              txe_irq,
    output logic              dma_tx_req,
    output logic              dma_rx_req
);
    always_comb begin
        err_irq    = flags[B_ER]  & rx_en;
        rxf_irq    = (flags[B_RDF] | flags[B_DR]) & rx_en;
        brk_irq    = flags[B_BRK] & rx_en;
        txe_irq    = flags[B_TDFE] & tx_en;
        dma_tx_req = flags[B_TDFE] & tx_en;
        dma_rx_req = flags[B_RDF] & rx_en;
    end

    // R8: a receive DMA request always comes with a receive interrupt
    assert_dma_rx_pairs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rx_req |-> rxf_irq);
endmodule

// File: rtl/irq_prio.sv
module irq_prio
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       err_irq,
    input  logic       rxf_irq,
    input  logic       brk_irq,
    input  logic       txe_irq,
    output logic [2:0] irq_src
);
    irq_src_t src;

    always_comb begin
        if (err_irq)      src = SRC_ERR;
        else if (rxf_irq) src = SRC_RXF;
        else if (brk_irq) src = SRC_BRK;
        else if (txe_irq) src = SRC_TXE;
        else              src = SRC_NONE;
        irq_src = src;
    end

    // R9: a lower-priority code never hides a higher active request
    assert_prio_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_src == SRC_BRK) |-> (!err_irq && !rxf_irq && brk_irq));
    assert_none_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_src == SRC_NONE) |-> !(err_irq || rxf_irq || brk_irq || txe_irq));
endmodule

// File: rtl/uart_irq_flagctl.sv
module uart_irq_flagctl
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_trig,
    input  logic [CNT_W-1:0]  rx_trig,
    input  logic              rx_err_evt,
    input  logic              brk_evt,
    input  logic              rdy_evt,
    input  logic              tx_irq_en,
    input  logic              rx_irq_en,
    input  logic              stat_rd,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wdata,
    output logic [STAT_W-1:0] stat_rdata,
    output logic              err_irq,
    output logic              rxf_irq,
    output logic              brk_irq,
    output logic              txe_irq,
    output logic              dma_tx_req,
    output logic              dma_rx_req,
    output logic [2:0]        irq_src
);
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;
    logic [STAT_W-1:0] flags;
    logic              tx_low;
    logic              rx_high;

    always_comb begin
        tx_low          = (tx_count <= tx_trig);
        rx_high         = (rx_count >= rx_trig);
        set_vec         = '0;
        set_vec[B_ER]   = rx_err_evt;
        set_vec[B_BRK]  = brk_evt;
        set_vec[B_DR]   = rdy_evt;
        set_vec[B_RDF]  = rx_high;
        set_vec[B_TDFE] = tx_low;
        clr_vec         = '1;
        clr_vec[B_RDF]  = !rx_high;
        clr_vec[B_TDFE] = !tx_low;
    end

    for (genvar g = 0; g < STAT_W; g++) begin : g_flag
        flag_cell #(.RESET_SET(g == B_TDFE)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_req (set_vec[g]),
            .clr_ok  (clr_vec[g]),
            .rd_stb  (stat_rd),
            .wr_stb  (stat_wr),
            .wr_bit  (stat_wdata[g]),
            .flag_o  (flags[g])
        );
    end

    assign stat_rdata = flags;

    irq_route u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .flags      (flags),
        .tx_en      (tx_irq_en),
        .rx_en      (rx_irq_en),
        .err_irq    (err_irq),
        .rxf_irq    (rxf_irq),
        .brk_irq    (brk_irq),
        .txe_irq    (txe_irq),
        .dma_tx_req (dma_tx_req),
        .dma_rx_req (dma_rx_req)
    );

    irq_prio u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .err_irq (err_irq),
        .rxf_irq (rxf_irq),
        .brk_irq (brk_irq),
        .txe_irq (txe_irq),
        .irq_src (irq_src)
    );

    // R3: a low transmit FIFO leaves the empty flag set on the next edge
    assert_tdfe_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= tx_trig) |=> stat_rdata[B_TDFE]);
    // R4: a full receive FIFO leaves the full flag set on the next edge
    assert_rdf_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count >= rx_trig) |=> stat_rdata[B_RDF]);
    // R6: a flag never falls on a cycle without a write
    assert_no_silent_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ($past(stat_rdata) & ~stat_rdata) == '0);
endmodule

// File: tb/test_uart_irq_flagctl.sv
`timescale 1ns/1ps
module test_uart_irq_flagctl;
    localparam int DEPTH = 8;
    localparam int CW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0] tx_count = '0, rx_count = '0, tx_trig = '0, rx_trig = 1;
    logic rx_err_evt = 0, brk_evt = 0, rdy_evt = 0;
    logic tx_irq_en = 0, rx_irq_en = 0;
    logic stat_rd = 0, stat_wr = 0;
    logic [4:0] stat_wdata = '0;
    logic [4:0] stat_rdata;
    logic err_irq, rxf_irq, brk_irq, txe_irq, dma_tx_req, dma_rx_req;
    logic [2:0] irq_src;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    uart_irq_flagctl #(.FIFO_DEPTH(DEPTH)) i_uart_irq_flagctl (
        .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .rx_count(rx_count),
        .tx_trig(tx_trig), .rx_trig(rx_trig), .rx_err_evt(rx_err_evt),
        .brk_evt(brk_evt), .rdy_evt(rdy_evt), .tx_irq_en(tx_irq_en),
        .rx_irq_en(rx_irq_en), .stat_rd(stat_rd), .stat_wr(stat_wr),
        .stat_wdata(stat_wdata), .stat_rdata(stat_rdata), .err_irq(err_irq),
        .rxf_irq(rxf_irq), .brk_irq(brk_irq), .txe_irq(txe_irq),
        .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req), .irq_src(irq_src)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    // read strobe for one cycle, then write 0 to every bit for one cycle
    task automatic rd_wr0();
        stat_rd = 1; cyc(); stat_rd = 0;
        stat_wr = 1; stat_wdata = '0; cyc(); stat_wr = 0;
    endtask

    task automatic clear_all();
        tx_count = CW'(DEPTH); rx_count = '0; cyc();
        rd_wr0();
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tx_trig = 2; rx_trig = 4; tx_count = '0; rx_count = '0;
        cyc(); cyc();
        // R1: reset state
        chk("R1 status", stat_rdata, 5'b10000);
        chk("R1 src", irq_src, 0);
        chk("R1 txe", txe_irq, 0);
        rst_n = 1;
        cyc();

        // R3: every transmit trigger against every count
        for (int t = 0; t <= DEPTH; t++) begin
            for (int c = 0; c <= DEPTH; c++) begin
                tx_trig = CW'(t); tx_count = '0; cyc();
                tx_count = CW'(c); cyc();
                chk("R3 held", stat_rdata[4], 1);
                rd_wr0();
                chk("R3 after clear", stat_rdata[4], (c <= t) ? 1 : 0);
            end
        end
        tx_count = CW'(DEPTH); tx_trig = 2;

        // R4: every receive trigger against every count
        for (int t = 1; t <= DEPTH; t++) begin
            for (int c = 0; c <= DEPTH; c++) begin
                rx_trig = CW'(t); rx_count = CW'(DEPTH); cyc();
                rx_count = CW'(c); cyc();
                chk("R4 held", stat_rdata[3], 1);
                rd_wr0();
                chk("R4 after clear", stat_rdata[3], (c >= t) ? 1 : 0);
            end
        end
        rx_trig = 4;

        // R5 and R6: write 0 without a read, then write 1 after a read
        clear_all();
        rx_err_evt = 1; cyc(); rx_err_evt = 0;
        chk("R5 error set", stat_rdata, 5'b00001);
        stat_wr = 1; stat_wdata = '0; cyc(); stat_wr = 0;
        chk("R6 write0 unread", stat_rdata, 5'b00001);
        stat_rd = 1; cyc(); stat_rd = 0;
        stat_wr = 1; stat_wdata = 5'b11111; cyc(); stat_wr = 0;
        chk("R6 write1 ignored", stat_rdata, 5'b00001);
        stat_wr = 1; stat_wdata = 5'b11110; cyc(); stat_wr = 0;
        chk("R5 armed write0 clears", stat_rdata, 5'b00000);

        // R8: data ready alone asks for the receive line but no DMA
        rx_irq_en = 1; tx_irq_en = 1;
        rdy_evt = 1; cyc(); rdy_evt = 0;
        chk("R8 rxf from ready", rxf_irq, 1);
        chk("R8 no dma from ready", dma_rx_req, 0);
        clear_all();

        // R7 R8 R9 R10: every flag combination under every enable pair
        for (int m = 0; m < 32; m++) begin
            for (int en = 0; en < 4; en++) begin
                logic e, b, d, r, x, re, te;
                int src;
                e = m[0]; b = m[1]; d = m[2]; r = m[3]; x = m[4];
                te = en[0]; re = en[1];
                tx_irq_en = te; rx_irq_en = re;
                clear_all();
                rx_err_evt = e; brk_evt = b; rdy_evt = d;
                tx_count = x ? '0 : CW'(DEPTH);
                rx_count = r ? CW'(DEPTH) : '0;
                cyc();
                rx_err_evt = 0; brk_evt = 0; rdy_evt = 0;
                cyc();
                chk("R2 R10 status", stat_rdata, {x, r, d, b, e});
                chk("R7 err", err_irq, e & re);
                chk("R7 rxf", rxf_irq, (r | d) & re);
                chk("R7 brk", brk_irq, b & re);
                chk("R7 txe", txe_irq, x & te);
                chk("R8 dma tx", dma_tx_req, x & te);
                chk("R8 dma rx", dma_rx_req, r & re);
                if (e & re) src = 1;
                else if ((r | d) & re) src = 2;
                else if (b & re) src = 3;
                else if (x & te) src = 4;
                else src = 0;
                chk("R9 src", irq_src, src);
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule